// File: doc/BRIEF.md
# Write-Only Power Rail Control Target on I2C

This block is an I2C target that accepts writes only and that sets which power outputs are switched on. A controller sends a START, the device address byte, one data byte and a STOP. When the address matches and the data byte is acknowledged, the byte becomes the new control value. Each bit of that value enables one power output. The exception is one bit that picks between two output voltage levels instead of enabling anything.

SCL and SDA arrive as raw wire levels. They are synchronised into the system clock, and START, STOP and SCL edges are found in that clock domain. The system clock runs at least sixteen times faster than SCL. The target acknowledges by asserting `sda_pull_o`, which drives the open-drain SDA line low.

A separate enable pin gates every output. Two outputs follow the enable pin alone. The others need both the enable pin and their bit in the control value.

Top module: `pwrctl_i2c_tgt`

## Requirements
- R1: After reset, `ctl_byte_o` is 8'h00, `sda_pull_o` is 0 and `vsel_hi_o` is 0. With `en_pin_i` low, every bit of `rail_on_o` is 0.
- R2: The only address byte accepted is 8'h10: the 7-bit address 7'h08 followed by a 0 write bit, sent MSB first. For that byte, `sda_pull_o` is 1 while SCL is high during the ninth clock.
- R3: Any other address byte gets no acknowledge, including 8'h11 (the read form of the same address). The rest of that transfer is ignored and `ctl_byte_o` stays unchanged until the next START.
- R4: After an accepted address, the target acknowledges the next byte (MSB first) on its ninth clock. `ctl_byte_o` takes that byte once SCL falls at the end of that ninth clock.
- R5: A STOP that arrives before the data byte has been acknowledged leaves `ctl_byte_o` unchanged.
- R6: A repeated START, sent without a STOP, restarts address reception whatever state the transfer was in. A matching address and data byte then update `ctl_byte_o`.
- R7: `rail_on_o[i]` is `en_pin_i & ctl_byte_o[i]` for i in {0,1,2,3,4,6}. `rail_on_o[5]` and `rail_on_o[7]` equal `en_pin_i`, whatever the control value holds.
- R8: `vsel_hi_o` equals control bit 5 (0 selects the lower voltage, 1 the higher). It does not depend on `en_pin_i`.
- R9: Any byte after the data byte in the same transfer gets no acknowledge and does not change `ctl_byte_o`.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. An SDA change while SCL is low is taken as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level (wired bus value) |
| en_pin_i | input | 1 | Master enable for all outputs |
| sda_pull_o | output | 1 | 1 = drive SDA low (acknowledge) |
| ctl_byte_o | output | 8 | Registered control value |
| rail_on_o | output | 8 | Per-output enables after gating |
| vsel_hi_o | output | 1 | Voltage select, 1 = higher level |

## Verification
The enable pin can change in the same cycle that a new control value is committed. When that happens, the gated outputs must show the new value and the new enable level together, with no cycle in which either one is stale. The bench flips `en_pin_i` exactly in the cycle in which its own model predicts the commit. It then compares every output against the model on every clock, so a one-cycle glitch or lag in either path is caught.

// File: rtl/pwrctl_pkg.sv
`timescale 1ns/1ps
package pwrctl_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } eng_state_t;

  // Address byte carries the 7-bit device address followed by R/W = 0.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [6:0]        dev);
    return rx == {dev, 1'b0};
  endfunction

endpackage

// File: rtl/pwrctl_line_sync.sv
`timescale 1ns/1ps
module pwrctl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  localparam int unsigned NLINE = 2;

  logic [NLINE-1:0] raw_v;
  logic [NLINE-1:0] lvl_v;
  logic [NLINE-1:0] prv_v;

  assign raw_v = {sda_raw, scl_raw};

  generate
    for (genvar ln = 0; ln < NLINE; ln++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
          prv_v[ln] <= 1'b1;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], raw_v[ln]};
          prv_v[ln] <= chain_q[STAGES-1];
        end
      end
      assign lvl_v[ln] = chain_q[STAGES-1];
    end
  endgenerate

  logic scl_l, scl_p, sda_p;
  assign scl_l   = lvl_v[0];
  assign scl_p   = prv_v[0];
  assign sda_lvl = lvl_v[1];
  assign sda_p   = prv_v[1];

  assign scl_rise  = scl_l & ~scl_p;
  assign scl_fall  = ~scl_l & scl_p;
  assign bus_start = scl_l & scl_p & sda_p & ~sda_lvl;
  assign bus_stop  = scl_l & scl_p & ~sda_p & sda_lvl;

  // R10: start and stop are never flagged on the same cycle as an SCL edge
  a_r10_cond_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |-> !(scl_rise || scl_fall));

  a_r10_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_start && bus_stop));

endmodule

// File: rtl/pwrctl_wr_engine.sv
`timescale 1ns/1ps
module pwrctl_wr_engine
  import pwrctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_drive,
  output logic              commit_ev,
  output logic [BYTE_W-1:0] commit_byte
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  eng_state_t        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              drv_q;
  logic              byte_done;
  logic              shift_ev;

  assign byte_done = (cnt_q == FULL);
  assign shift_ev  = scl_rise && !byte_done &&
                     (st_q == ST_ADDR || st_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      drv_q <= 1'b0;
    end else if (bus_start) begin
      st_q  <= ST_ADDR;
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else if (bus_stop) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_DATA: begin
          if (shift_ev) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            if (st_q == ST_DATA) begin
              st_q  <= ST_DACK;
              drv_q <= 1'b1;
            end else if (addr_hit(sh_q, DEV_ADDR)) begin
              st_q  <= ST_AACK;
              drv_q <= 1'b1;
            end else begin
              st_q  <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            drv_q <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_DATA;
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            drv_q <= 1'b0;
            st_q  <= ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive   = drv_q;
  assign commit_ev   = (st_q == ST_DACK) && scl_fall && !bus_start && !bus_stop;
  assign commit_byte = sh_q;

  // R2: acknowledge is raised only right after SCL has fallen
  a_r2_ack_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive) |-> $past(scl_fall));

  // R3: a transfer being ignored never pulls SDA
  a_r3_skip_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> !sda_drive);

  // R4: a commit happens only while the acknowledge is being driven
  a_r4_commit_during_ack: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> sda_drive);

  // R5: a stop always releases the line
  a_r5_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_drive);

  // R6: a start re-arms address reception from bit zero
  a_r6_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (st_q == ST_ADDR && cnt_q == '0));

  // R9: no acknowledge while a byte is still being shifted in
  a_r9_no_pull_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA || st_q == ST_ADDR) |-> !sda_drive);

endmodule

// File: rtl/pwrctl_rail_gate.sv
`timescale 1ns/1ps
module pwrctl_rail_gate
  import pwrctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ENONLY_MASK = 8'b1010_0000,
  parameter int unsigned       VSEL_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_ev,
  input  logic [BYTE_W-1:0] commit_byte,
  input  logic              en_pin,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [BYTE_W-1:0] rail_on,
  output logic              vsel_hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl_q <= '0;
    else if (commit_ev) ctl_q <= commit_byte;
  end

  generate
    for (genvar b = 0; b < BYTE_W; b++) begin : g_rail
      if (ENONLY_MASK[b]) begin : g_pin_only
        assign rail_on[b] = en_pin;
      end else begin : g_reg_ctl
        assign rail_on[b] = en_pin & ctl_q[b];
      end
    end
  endgenerate

  assign vsel_hi = ctl_q[VSEL_BIT];

  // R7: with the enable pin low nothing is on
  a_r7_pin_masks_all: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |-> (rail_on == '0));

  // R7: with the pin high, pin-only outputs are on
  a_r7_pin_only_follow: assert property (@(posedge clk) disable iff (!rst_n)
    en_pin |-> ((rail_on & ENONLY_MASK) == ENONLY_MASK));

  // R4: the control value only moves on a commit
  a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(ctl_q));

endmodule

// File: rtl/pwrctl_i2c_tgt.sv
`timescale 1ns/1ps
module pwrctl_i2c_tgt
  import pwrctl_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h08,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] ENONLY_MASK = 8'b1010_0000,
  parameter int unsigned       VSEL_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              en_pin_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] ctl_byte_o,
  output logic [BYTE_W-1:0] rail_on_o,
  output logic              vsel_hi_o
);

  logic              sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic              commit_ev;
  logic [BYTE_W-1:0] commit_byte;

  pwrctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  pwrctl_wr_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .sda_drive   (sda_pull_o),
    .commit_ev   (commit_ev),
    .commit_byte (commit_byte)
  );

  pwrctl_rail_gate #(.ENONLY_MASK(ENONLY_MASK), .VSEL_BIT(VSEL_BIT)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_ev   (commit_ev),
    .commit_byte (commit_byte),
    .en_pin      (en_pin_i),
    .ctl_q       (ctl_byte_o),
    .rail_on     (rail_on_o),
    .vsel_hi     (vsel_hi_o)
  );

  // R8: voltage select only moves together with the control value
  a_r8_vsel_tracks_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctl_byte_o) |-> $stable(vsel_hi_o));

endmodule

// File: tb/test_pwrctl_i2c_tgt.sv
`timescale 1ns/1ps
module test_pwrctl_i2c_tgt;

  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       en_pin = 1'b0;
  logic       sda_pull;
  logic [7:0] ctl_byte;
  logic [7:0] rail_on;
  logic       vsel_hi;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  pwrctl_i2c_tgt i_pwrctl_i2c_tgt (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .en_pin_i   (en_pin),
    .sda_pull_o (sda_pull),
    .ctl_byte_o (ctl_byte),
    .rail_on_o  (rail_on),
    .vsel_hi_o  (vsel_hi)
  );

  always #2.5 clk = ~clk;

  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  int   commit_at = -1;
  logic [7:0] pend = 8'h00;
  logic [7:0] exp_ctl = 8'h00;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] model_rails(input logic [7:0] c, input logic e);
    logic [7:0] r;
    r = 8'h00;
    if (e) begin
      r[7] = 1'b1;               // pin-only output
      r[5] = 1'b1;               // pin-only output
      r[6] = c[6];
      r[4] = c[4];
      r[3] = c[3];
      r[2] = c[2];
      r[1] = c[1];
      r[0] = c[0];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, expv);
    end
  endtask

  // Reference model compared on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      if (cyc == commit_at) exp_ctl = pend;
      check("R4 ctl", ctl_byte, exp_ctl);
      check("R7 rails", rail_on, model_rails(exp_ctl, en_pin));
      check("R8 vsel", {7'd0, vsel_hi}, {7'd0, exp_ctl[5]});
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(HALF/2);
    scl_m = 1'b1; wait_n(HALF);
    sda_m = 1'b0; wait_n(HALF);
    scl_m = 1'b0; wait_n(HALF/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(HALF/2);
    scl_m = 1'b1; wait_n(HALF);
    sda_m = 1'b1; wait_n(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wait_n(HALF/2);
    scl_m = 1'b1; wait_n(HALF);
    scl_m = 1'b0; wait_n(HALF/2);
  endtask

  // Sends one byte and its ack clock; commit requests a model update at
  // the closing SCL fall, flip_en toggles the pin in the commit cycle.
  task automatic send_byte(input logic [7:0] b, input bit commit,
                           input bit flip_en, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_n(HALF/2);
    scl_m = 1'b1; wait_n(HALF/2);
    acked = sda_pull;
    wait_n(HALF/2);
    scl_m = 1'b0;
    if (commit) begin
      pend = b;
      commit_at = cyc + 3;
    end
    if (flip_en) begin
      wait_n(3);
      en_pin = ~en_pin;
      wait_n(HALF/2 - 3);
    end else begin
      wait_n(HALF/2);
    end
  endtask

  logic ak;

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    // R1: reset state
    check("R1 ctl", ctl_byte, 8'h00);
    check("R1 pull", {7'd0, sda_pull}, 8'h00);
    check("R1 rails", rail_on, 8'h00);
    en_pin = 1'b1;
    wait_n(2);
    check("R7 pin-only", rail_on, 8'hA0);

    // R2 / R4: plain write
    bus_start();
    send_byte(8'h10, 0, 0, ak); check("R2 addr ack", {7'd0, ak}, 8'h01);
    send_byte(8'h5A, 1, 0, ak); check("R4 data ack", {7'd0, ak}, 8'h01);
    bus_stop();
    check("R4 value", ctl_byte, 8'h5A);

    // Enable change in the commit cycle
    bus_start();
    send_byte(8'h10, 0, 0, ak); check("R2 addr ack", {7'd0, ak}, 8'h01);
    send_byte(8'h3F, 1, 1, ak); check("R4 data ack", {7'd0, ak}, 8'h01);
    bus_stop();
    check("R7 pin low", rail_on, 8'h00);
    check("R8 vsel ungated", {7'd0, vsel_hi}, 8'h01);
    en_pin = 1'b1;
    wait_n(2);
    check("R7 gated", rail_on, 8'hBF);

    // R3: wrong address and read form
    bus_start();
    send_byte(8'h20, 0, 0, ak); check("R3 nack other", {7'd0, ak}, 8'h00);
    send_byte(8'hFF, 0, 0, ak); check("R3 data ignored", {7'd0, ak}, 8'h00);
    bus_stop();
    bus_start();
    send_byte(8'h11, 0, 0, ak); check("R3 nack read", {7'd0, ak}, 8'h00);
    send_byte(8'h00, 0, 0, ak);
    bus_stop();
    check("R3 unchanged", ctl_byte, 8'h3F);

    // R5: stop in the middle of the data byte
    bus_start();
    send_byte(8'h10, 0, 0, ak);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_stop();
    check("R5 abort", ctl_byte, 8'h3F);

    // R6: repeated start after an accepted address and after a mismatch
    bus_start();
    send_byte(8'h10, 0, 0, ak);
    bus_start();
    send_byte(8'h10, 0, 0, ak); check("R6 re-addr ack", {7'd0, ak}, 8'h01);
    send_byte(8'h81, 1, 0, ak);
    bus_stop();
    check("R6 value", ctl_byte, 8'h81);
    bus_start();
    send_byte(8'h22, 0, 0, ak);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'h10, 0, 0, ak); check("R6 after skip", {7'd0, ak}, 8'h01);
    send_byte(8'h14, 1, 0, ak);
    bus_stop();
    check("R6 value2", ctl_byte, 8'h14);

    // R9: extra byte in the same transfer
    bus_start();
    send_byte(8'h10, 0, 0, ak);
    send_byte(8'h0C, 1, 0, ak);
    send_byte(8'hF3, 0, 0, ak); check("R9 extra nack", {7'd0, ak}, 8'h00);
    bus_stop();
    check("R9 value", ctl_byte, 8'h0C);

    // R10: SDA wiggles with SCL low and no start: no effect
    for (int i = 0; i < 4; i++) begin
      scl_m = 1'b0; wait_n(4);
      sda_m = ~sda_m; wait_n(4);
    end
    sda_m = 1'b1; wait_n(4); scl_m = 1'b1; wait_n(HALF);
    send_bit(1'b1);
    check("R10 no pull", {7'd0, sda_pull}, 8'h00);
    check("R10 value", ctl_byte, 8'h0C);

    wait_n(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule